// File: doc/BRIEF.md
# Latency-Capped Slave Port Arbiter

This block decides which master may drive a single memory slave port. Master 0 is a fixed-priority master, typically a processor data path. Masters 1 to N_WRR are weighted round-robin masters, typically DMA engines. Each master raises a request while it has a burst to move. It states the burst length while requesting and marks each beat it is ready to move with a beat-valid line. A beat transfers on every cycle in which that master is granted and its beat-valid is high.

When a weighted master wins the port, it keeps it for a run of beats. The run ends once the master's burst is finished or once the run reaches the smaller of the master's programmed weight and the slave's programmed latency ceiling, whichever comes first. At that point arbitration takes place again. A fixed-priority master that has been waiting wins, so its wait behind a weighted master is bounded by min(weight, ceiling) beats. A cut-short burst is not lost: the arbiter remembers how many beats remain and resumes the burst at the master's next grant.

The grant outputs are one-hot, and a registered index with a valid flag steers the slave-side data multiplexer. Bus protocol decoding and the memory behind the port lie outside this block.

Top module: `lat_cap_arbiter`

## Requirements
- R1: While reset is high, and on the cycle after it is released with no request pending, `gnt_o` is all zeros, `gnt_vld_o` is 0 and `gnt_idx_o` is 0.
- R2: At most one bit of `gnt_o` is set. When `gnt_vld_o` is 1, bit `gnt_idx_o` of `gnt_o` is the set bit. Index 0 is the fixed-priority master and index k (1..N_WRR) is weighted master k. When `gnt_vld_o` is 0, `gnt_o` and `gnt_idx_o` are zero.
- R3: A grant changes only on the clock edge that ends a cycle in which the granted master moved a beat. When that beat ends the holder's turn, the next grant appears on that same edge, without an idle cycle. Any request seen while no grant is held is granted on the next edge.
- R4: Whenever arbitration takes place, a requesting fixed-priority master wins over all weighted masters.
- R5: The fixed-priority master keeps its grant until every beat of its burst has moved. Its beats are never cut off by the latency ceiling.
- R6: A weighted master's run ends after min(max(weight,1), max(ceiling,1)) beats, or at its burst's last beat if that comes first. A weight or a ceiling of 0 therefore gives 1-beat runs. Weight k is `weight_i[(k-1)*CNT_W +: CNT_W]` and the ceiling is `maxlat_i`.
- R7: A burst length is taken from `blen_i[m*CNT_W +: CNT_W]` when master m is granted with no beats outstanding, with 0 taken as 1. A burst whose run was cut short resumes with its remaining beats at the master's next grant, and `blen_i` is not sampled again.
- R8: If a weighted master reaches its run limit and no other master is eligible, it is granted again on the same edge. Its run count starts over.
- R9: When no fixed-priority request is eligible, the weighted masters are served in round-robin order, starting from the one after the weighted master granted last. After reset, master 1 comes first.
- R10: The weight and ceiling are sampled when a grant is issued. A change during a run takes effect from the next arbitration.
- R11: A master whose burst completes on the current cycle is excluded from that cycle's arbitration. If its request is still high in the following cycle, that request counts as a new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_WRR+1 | Per-master request, held high until the burst's last beat has moved |
| beat_i | input | N_WRR+1 | Per-master beat-valid; a beat moves when this is high while granted |
| blen_i | input | (N_WRR+1)*CNT_W | Per-master burst length, field m at m*CNT_W |
| weight_i | input | N_WRR*CNT_W | Weight of weighted master k at (k-1)*CNT_W |
| maxlat_i | input | CNT_W | Slave latency ceiling in beats |
| gnt_o | output | N_WRR+1 | One-hot grant, registered |
| gnt_idx_o | output | $clog2(N_WRR+1) | Index of the granted master for the slave mux |
| gnt_vld_o | output | 1 | A grant is held |

## Verification
The bound checker watches, on every cycle, the grant vector's shape and its agreement with the index, that a grant never moves without a beat, that a request left waiting on an idle port is granted on the next edge, and that the beats a waiting fixed-priority master sits through never exceed the ceiling. The exact length of each run, the resumption of a cut-short burst from its remaining count, round-robin order, the sampling instant of weight and ceiling, and the exclusion of a just-finished master can be seen only in the bench. The bench shows them by comparing against its reference model on every clock and by checking beat-by-beat owner sequences in directed scenarios.

// File: rtl/lca_pkg.sv
package lca_pkg;
  // A programmed value of zero still allows one beat.
  function automatic int unsigned at_least_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Beats a weighted master may move in one run.
  function automatic int unsigned run_limit(int unsigned wgt, int unsigned ceil_v);
    int unsigned a;
    int unsigned b;
    a = at_least_one(wgt);
    b = at_least_one(ceil_v);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lca_rr_pick.sv
module lca_rr_pick #(
  parameter int N    = 2,
  parameter int RR_W = 1
) (
  input  logic [N-1:0]    elig,
  input  logic [RR_W-1:0] last,
  output logic            found,
  output logic [RR_W-1:0] pick
);
  int c;
  // Walk from the farthest candidate back to the nearest one, so the
  // nearest eligible master after `last` is the one left standing.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    c     = 0;
    for (int k = N; k >= 1; k--) begin
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (elig[c]) begin
        found = 1'b1;
        pick  = RR_W'(c);
      end
    end
  end
endmodule

// File: rtl/lca_burst_cnt.sv
module lca_burst_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] blen,
  input  logic             xfer,
  output logic             fin
);
  logic [CNT_W-1:0] rem_q;

  // Beats still owed by this master's current burst; zero means no burst open.
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load && rem_q == '0) begin
      rem_q <= (blen == '0) ? CNT_W'(1) : blen;
    end else if (xfer && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign fin = xfer && (rem_q == CNT_W'(1));
endmodule

// File: rtl/lca_run_ctl.sv
module lca_run_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] lim_in,
  input  logic             xfer,
  output logic             cap_hit
);
  logic [CNT_W:0]   run_q;
  logic [CNT_W-1:0] lim_q;

  // The limit is frozen at grant time; the counter restarts on every grant.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lim_q <= CNT_W'(1);
    end else if (start) begin
      run_q <= '0;
      lim_q <= lim_in;
    end else if (xfer) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign cap_hit = xfer && ((run_q + 1'b1) >= {1'b0, lim_q});
endmodule

// File: rtl/lat_cap_arbiter.sv
module lat_cap_arbiter
  import lca_pkg::*;
#(
  parameter int N_WRR = 2,
  parameter int CNT_W = 8,
  localparam int NM    = N_WRR + 1,
  localparam int IDX_W = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NM-1:0]         req_i,
  input  logic [NM-1:0]         beat_i,
  input  logic [NM*CNT_W-1:0]   blen_i,
  input  logic [N_WRR*CNT_W-1:0] weight_i,
  input  logic [CNT_W-1:0]      maxlat_i,
  output logic [NM-1:0]         gnt_o,
  output logic [IDX_W-1:0]      gnt_idx_o,
  output logic                  gnt_vld_o
);
  localparam int RR_W = (N_WRR > 1) ? $clog2(N_WRR) : 1;

  logic             own_vld_q;
  logic [IDX_W-1:0] own_q;
  logic [NM-1:0]    gnt_q;
  logic [RR_W-1:0]  rr_q;

  logic [NM-1:0]    xfer;
  logic [NM-1:0]    fin;
  logic [NM-1:0]    elig;
  logic [CNT_W-1:0] wgt [N_WRR];
  logic             own_xfer;
  logic             cap_hit;
  logic             release_now;
  logic             free;
  logic             rr_found;
  logic [RR_W-1:0]  rr_pick;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [RR_W-1:0]  win_wpos;
  logic             grant_now;
  logic [CNT_W-1:0] lim_in;

  for (genvar k = 0; k < N_WRR; k++) begin : g_wgt
    assign wgt[k] = weight_i[k*CNT_W +: CNT_W];
  end

  assign xfer     = gnt_q & beat_i;
  assign own_xfer = |xfer;

  // One remaining-beat tracker per master
  for (genvar m = 0; m < NM; m++) begin : g_burst
    lca_burst_cnt #(.CNT_W(CNT_W)) u_burst (
      .clk  (clk),
      .rst  (rst),
      .load (grant_now && win_idx == IDX_W'(m)),
      .blen (blen_i[m*CNT_W +: CNT_W]),
      .xfer (xfer[m]),
      .fin  (fin[m])
    );
  end

  // A master closing its burst this cycle does not re-enter arbitration.
  assign elig = req_i & ~fin;

  lca_rr_pick #(.N(N_WRR), .RR_W(RR_W)) u_pick (
    .elig  (elig[NM-1:1]),
    .last  (rr_q),
    .found (rr_found),
    .pick  (rr_pick)
  );

  always_comb begin
    win_any = 1'b1;
    if (elig[0]) begin
      win_idx = '0;
    end else if (rr_found) begin
      win_idx = IDX_W'(rr_pick) + 1'b1;
    end else begin
      win_idx = '0;
      win_any = 1'b0;
    end
  end

  assign win_wpos = (win_idx == '0) ? '0 : RR_W'(win_idx - 1'b1);
  assign lim_in   = CNT_W'(run_limit(32'(wgt[win_wpos]), 32'(maxlat_i)));

  lca_run_ctl #(.CNT_W(CNT_W)) u_run (
    .clk     (clk),
    .rst     (rst),
    .start   (grant_now),
    .lim_in  (lim_in),
    .xfer    (own_xfer),
    .cap_hit (cap_hit)
  );

  // Only weighted holders are bounded by the run limit.
  assign release_now = (|fin) || (own_vld_q && own_q != '0 && cap_hit);
  assign free        = !own_vld_q || release_now;
  assign grant_now   = free && win_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      gnt_q     <= '0;
      rr_q      <= RR_W'(N_WRR - 1);
    end else if (free) begin
      own_vld_q <= win_any;
      own_q     <= win_any ? win_idx : '0;
      gnt_q     <= win_any ? (NM'(1) << win_idx) : '0;
      if (grant_now && win_idx != '0) rr_q <= win_wpos;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_idx_o = own_q;
  assign gnt_vld_o = own_vld_q;
endmodule

// File: rtl/lca_arb_chk.sv
module lca_arb_chk
  import lca_pkg::*;
#(
  parameter int N_WRR = 2,
  parameter int CNT_W = 8,
  localparam int NM    = N_WRR + 1,
  localparam int IDX_W = (NM > 1) ? $clog2(NM) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NM-1:0]    req_i,
  input logic [NM-1:0]    beat_i,
  input logic [CNT_W-1:0] maxlat_i,
  input logic [NM-1:0]    gnt_o,
  input logic [IDX_W-1:0] gnt_idx_o,
  input logic             gnt_vld_o
);
  // Weighted-master beats seen while the fixed-priority master waits
  logic [CNT_W:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i[0] || gnt_o[0]) begin
      wait_q <= '0;
    end else if (gnt_vld_o && beat_i[gnt_idx_o]) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)); // R2

  AST_IDX_AGREES: assert property (@(posedge clk) disable iff (rst)
    gnt_vld_o |-> gnt_o[gnt_idx_o]); // R2

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !gnt_vld_o |-> (gnt_o == '0 && gnt_idx_o == '0)); // R1

  AST_HOLD_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && !beat_i[gnt_idx_o]) |=> (gnt_vld_o && gnt_idx_o == $past(gnt_idx_o))); // R3

  AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    ((|req_i) && !gnt_vld_o) |=> gnt_vld_o); // R3

  AST_FIXED_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld_o && req_i[0]) |=> gnt_o[0]); // R4

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (req_i[0] && !gnt_o[0]) |-> (32'(wait_q) <= at_least_one(32'(maxlat_i)))); // R6
endmodule

bind lat_cap_arbiter lca_arb_chk #(.N_WRR(N_WRR), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .beat_i    (beat_i),
  .maxlat_i  (maxlat_i),
  .gnt_o     (gnt_o),
  .gnt_idx_o (gnt_idx_o),
  .gnt_vld_o (gnt_vld_o)
);

// File: tb/test_lat_cap_arbiter.sv
module test_lat_cap_arbiter;
  localparam int N_WRR = 2;
  localparam int CNT_W = 8;
  localparam int NM    = N_WRR + 1;
  localparam int IDX_W = $clog2(NM);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM-1:0]          req  = '0;
  logic [NM-1:0]          beat = '0;
  logic [NM*CNT_W-1:0]    blen = '0;
  logic [N_WRR*CNT_W-1:0] wgt  = '0;
  logic [CNT_W-1:0]       cap  = '0;
  logic [NM-1:0]          gnt_o;
  logic [IDX_W-1:0]       gnt_idx_o;
  logic                   gnt_vld_o;

  always #2 clk = ~clk;

  lat_cap_arbiter #(.N_WRR(N_WRR), .CNT_W(CNT_W)) i_lat_cap_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .beat_i(beat), .blen_i(blen),
    .weight_i(wgt), .maxlat_i(cap), .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o),
    .gnt_vld_o(gnt_vld_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit chk_en = 0;
  int dens = 100;
  int gaps = 0;
  int w_set [NM];
  int cap_set = 1;

  // bench-side masters
  int q [NM][$];
  int mrem [NM];
  bit mact [NM];
  int beat_log [$];

  // reference model
  int m_own, m_run, m_lim, m_rr;
  int m_rem [NM];

  task automatic check(bit ok, string what, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  task automatic model_step();
    int done, finished, win, c, a, b;
    if (rst) begin
      m_own = -1; m_run = 0; m_lim = 1; m_rr = N_WRR;
      for (int m = 0; m < NM; m++) m_rem[m] = 0;
      return;
    end
    done = 0; finished = -1;
    if (m_own >= 0 && beat[m_own]) begin
      m_rem[m_own]--;
      m_run++;
      if (m_rem[m_own] == 0) begin done = 1; finished = m_own; end
      else if (m_own > 0 && m_run >= m_lim) done = 1;
    end
    if (m_own < 0 || done) begin
      win = -1;
      if (req[0] && finished != 0) win = 0;
      else begin
        for (int k = 1; k <= N_WRR; k++) begin
          c = ((m_rr - 1 + k) % N_WRR) + 1;
          if (win < 0 && req[c] && finished != c) win = c;
        end
      end
      m_own = win;
      if (win >= 0) begin
        m_run = 0;
        if (m_rem[win] == 0) begin
          m_rem[win] = int'(blen[win*CNT_W +: CNT_W]);
          if (m_rem[win] == 0) m_rem[win] = 1;
        end
        if (win > 0) begin
          a = (w_set[win] == 0) ? 1 : w_set[win];
          b = (cap_set == 0) ? 1 : cap_set;
          m_lim = (a < b) ? a : b;
          m_rr = win;
        end
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    ncyc++;
    if (chk_en) begin
      logic [NM-1:0] eg;
      eg = (m_own >= 0) ? (NM'(1) << m_own) : '0;
      check(gnt_o == eg && gnt_vld_o == (m_own >= 0) &&
            int'(gnt_idx_o) == ((m_own >= 0) ? m_own : 0),
            "R3 per-cycle grant vs model",
            $sformatf("gnt=%b idx=%0d vld=%0d", gnt_o, gnt_idx_o, gnt_vld_o),
            $sformatf("gnt=%b idx=%0d vld=%0d", eg, (m_own >= 0) ? m_own : 0, m_own >= 0));
    end
    for (int k = 1; k < NM; k++) wgt[(k-1)*CNT_W +: CNT_W] = CNT_W'(w_set[k]);
    cap = CNT_W'(cap_set);
    for (int m = 0; m < NM; m++) begin
      if (!mact[m] && q[m].size() > 0) begin
        mrem[m] = (q[m][0] == 0) ? 1 : q[m][0];
        mact[m] = 1;
      end
      req[m] = mact[m];
      blen[m*CNT_W +: CNT_W] = mact[m] ? CNT_W'(q[m][0]) : '0;
      beat[m] = (int'($urandom_range(99)) < dens);
    end
    if (!rst && (|req) && !gnt_vld_o) gaps++;
    for (int m = 0; m < NM; m++) begin
      if (!rst && gnt_o[m] && beat[m] && mact[m]) begin
        beat_log.push_back(m);
        mrem[m]--;
        if (mrem[m] == 0) begin
          void'(q[m].pop_front());
          mact[m] = 0;
        end
      end
    end
    model_step();
  endtask

  task automatic do_reset();
    rst = 1;
    for (int m = 0; m < NM; m++) begin q[m].delete(); mact[m] = 0; mrem[m] = 0; end
    cycle(); cycle();
    rst = 0;
    cycle();
    chk_en = 1;
    check(gnt_o == '0 && gnt_vld_o == 1'b0 && gnt_idx_o == '0, "R1 idle after reset",
          $sformatf("gnt=%b idx=%0d vld=%0d", gnt_o, gnt_idx_o, gnt_vld_o), "gnt=000 idx=0 vld=0");
    beat_log.delete();
    gaps = 0;
  endtask

  function automatic bit busy();
    for (int m = 0; m < NM; m++) if (mact[m] || q[m].size() > 0) return 1;
    return 0;
  endfunction

  task automatic run_idle(string tag);
    int t = 0;
    while (busy() && t < 3000) begin cycle(); t++; end
    if (t >= 3000) check(0, {tag, " watchdog"}, "hung", "bursts drained");
    cycle(); cycle();
  endtask

  function automatic string qstr(int v [$]);
    string s = "";
    foreach (v[i]) s = {s, $sformatf("%0d", v[i])};
    return s;
  endfunction

  task automatic check_log(string tag, int exp [$]);
    bit ok = (beat_log.size() == exp.size());
    if (ok) foreach (exp[i]) if (beat_log[i] != exp[i]) ok = 0;
    check(ok, tag, qstr(beat_log), qstr(exp));
  endtask

  // global watchdog
  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) w_set[m] = 1;
    do_reset();

    // R4 R6 R7: ceiling 4, weight 8; weighted burst 8, fixed burst 4 arrives later
    w_set[1] = 8; cap_set = 4; do_reset();
    q[1].push_back(8); cycle(); cycle();
    q[0].push_back(4);
    run_idle("R7");
    check_log("R7 cut-short burst resumes after fixed master (R4 R6)", '{1,1,1,1,0,0,0,0,1,1,1,1});

    // R6: weight 18 ceiling 4 -> runs of 4
    w_set[1] = 18; w_set[2] = 18; cap_set = 4; do_reset();
    q[1].push_back(6); q[2].push_back(2);
    run_idle("R6a");
    check_log("R6 run limited by ceiling", '{1,1,1,1,2,2,1,1});

    // R6: weight 2 ceiling 6 -> runs of 2
    w_set[1] = 2; w_set[2] = 2; cap_set = 6; do_reset();
    q[1].push_back(4); q[2].push_back(4);
    run_idle("R9");
    check_log("R9 round-robin alternation with weight-limited runs (R6)", '{1,1,2,2,1,1,2,2});

    // R6: zero weight and zero ceiling treated as one
    w_set[1] = 0; w_set[2] = 0; cap_set = 5; do_reset();
    q[1].push_back(3); q[2].push_back(3);
    run_idle("R6b");
    check_log("R6 zero weight gives 1-beat runs", '{1,2,1,2,1,2});
    w_set[1] = 5; w_set[2] = 5; cap_set = 0; do_reset();
    q[1].push_back(2); q[2].push_back(2);
    run_idle("R6c");
    check_log("R6 zero ceiling gives 1-beat runs", '{1,2,1,2});

    // R5: fixed burst longer than ceiling is not cut
    w_set[1] = 8; cap_set = 2; do_reset();
    q[0].push_back(6); q[1].push_back(3);
    run_idle("R5");
    check_log("R5 fixed burst uncapped", '{0,0,0,0,0,0,1,1,1});

    // R8: sole weighted master re-granted without gaps
    w_set[1] = 3; cap_set = 8; do_reset();
    q[1].push_back(7);
    run_idle("R8");
    check_log("R8 sole master runs all beats", '{1,1,1,1,1,1,1});
    check(gaps == 1, "R8 no idle cycle at run boundaries", $sformatf("%0d", gaps), "1");

    // R10: weight change during a run applies from the next grant
    w_set[1] = 4; cap_set = 8; do_reset();
    q[1].push_back(6); cycle(); cycle();
    w_set[1] = 1; q[0].push_back(1);
    run_idle("R10");
    check_log("R10 weight sampled at grant", '{1,1,1,1,0,1,1});

    // R11: finished fixed master yields to a waiting weighted master
    w_set[1] = 8; cap_set = 8; do_reset();
    q[0].push_back(2); q[0].push_back(2); q[1].push_back(2);
    run_idle("R11");
    check_log("R11 completed master excluded from same-cycle arbitration", '{0,0,1,1,0,0});

    // R3 R2: random traffic with beat gaps, compared to the model every cycle
    do_reset();
    for (int r = 0; r < 8; r++) begin
      w_set[1] = $urandom_range(9); w_set[2] = $urandom_range(9);
      cap_set = $urandom_range(9);
      dens = 40 + $urandom_range(60);
      for (int t = 0; t < 400; t++) begin
        if ($urandom_range(99) < 6) q[$urandom_range(NM-1)].push_back($urandom_range(10));
        cycle();
      end
      run_idle("R3 random");
    end
    dens = 100;
    check(!gnt_vld_o && gnt_o == '0, "R2 idle after random traffic",
          $sformatf("gnt=%b vld=%0d", gnt_o, gnt_vld_o), "gnt=000 vld=0");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule